// File: doc/BRIEF.md
# SPI Flash Boot Copy Engine

This block is a hardware sequencer that runs once after reset and fills on-chip RAM with an image held in a serial NOR flash. It drives the four SPI pins itself in clock mode 3, where the clock idles high. The sequence is fixed. It wakes the flash from deep sleep with a short command frame. It then opens a read frame at a fixed start address and streams back-to-back 16-bit words into a RAM write port. Once the last word is stored, it sends the flash back to deep power-down. Finally it floats its pins and signals completion.

Two strap inputs are sampled in the first clock cycle after reset. The boot strap chooses between copying and skipping the copy entirely, so that an alternate loader can take over. The swap strap chooses whether the two bytes of every received word are exchanged before the word is stored. Every stored word is also handed to an external CRC accumulator in the same cycle. That accumulator receives a clear pulse before the first word.

The copy covers every RAM word address from a start address up to, but not including, an end address, in steps of two bytes. With the default parameters this is 0x4000 to 0x10000 in a 20-bit space.

Top module: `spiboot_copy`

## Requirements
- R1: The SPI link uses mode 3. While the pins are driven and no frame is open, spi_sclk is high. spi_mosi changes only while spi_sclk is low, and spi_miso is sampled on the rising clock edge.
- R2: The first frame holds exactly 8 clocks carrying byte 0xAB, most significant bit first. spi_cs_n rises only in the cycle after the shifter reports the transfer complete.
- R3: The second frame uses 16-bit transfers. Its first 32 bits on spi_mosi are 0x03, then a zero byte, then the 16-bit START_ADDR (0x4000 by default).
- R4: After those 32 bits, the read frame carries only zero bits on spi_mosi. It holds exactly 32 + 16 × (END_ADDR − START_ADDR)/2 clocks, with one 16-bit transfer per stored word.
- R5: The word received in data transfer k is written with ram_we at ram_addr = START_ADDR + 2k. The first flash byte is in bits 15:8. The last write goes to END_ADDR − 2 and lands in the same cycle that spi_cs_n rises. Nothing is written outside the range.
- R6: When swap_strap was high in the first cycle after reset, bits 15:8 and 7:0 of each word are exchanged before the write. A change of swap_strap later in the copy has no effect.
- R7: crc_clear pulses once before the first write. crc_valid and crc_data equal ram_we and ram_wdata in every write cycle.
- R8: The third and last frame holds exactly 8 clocks carrying 0xB9.
- R9: Between two frames, spi_cs_n stays high for at least two SPI clock periods (4 × DIV system cycles).
- R10: When boot_strap was low in the first cycle after reset, no frame is opened, spi_oe stays low and nothing is written. done pulses once with skipped high.
- R11: After the power-down frame, spi_oe falls first. done then pulses for exactly one cycle, with spi_oe already low and skipped low. The block stays quiet until the next reset.
- R12: During reset, spi_oe, done, ram_we, crc_valid and crc_clear are low, and spi_cs_n and spi_sclk are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_strap | input | 1 | High: run the copy; low: skip it |
| swap_strap | input | 1 | High: exchange the bytes of each word |
| spi_miso | input | 1 | Serial data from flash |
| spi_sclk | output | 1 | SPI clock, idles high |
| spi_mosi | output | 1 | Serial data to flash |
| spi_cs_n | output | 1 | Active-low flash select |
| spi_oe | output | 1 | Output enable for the SPI pins (low means high impedance) |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | AW | RAM byte address of the word |
| ram_wdata | output | 16 | RAM write data |
| crc_clear | output | 1 | Clears the CRC accumulator |
| crc_valid | output | 1 | CRC input word valid |
| crc_data | output | 16 | CRC input word |
| done | output | 1 | One-cycle completion pulse |
| skipped | output | 1 | Copy was skipped by the boot strap |

## Verification
Storing the final word and closing the read frame happen in the same cycle. The shifter's completion of the last data transfer drives both the RAM write and the rise of chip select. Every copy run reaches this point, and the bench requires spi_cs_n to be high exactly when the last address appears on the RAM port. It also requires the read frame to hold the exact clock count, with no extra transfer and no missing one. A second run flips swap_strap in the middle of streaming, so that a late strap sample would collide with stores and be caught in the data.

// File: rtl/spiboot_pkg.sv
`timescale 1ns/1ps
package spiboot_pkg;

  localparam logic [7:0] CMD_WAKE  = 8'hAB;
  localparam logic [7:0] CMD_READ  = 8'h03;
  localparam logic [7:0] CMD_SLEEP = 8'hB9;

  typedef enum logic [3:0] {
    S_STRAP, S_CLR, S_WAKE_GO, S_WAKE_RUN, S_GAP1, S_CMD_GO, S_CMD_RUN,
    S_ADDR_RUN, S_DATA_RUN, S_GAP2, S_SLEEP_GO, S_SLEEP_RUN, S_REL, S_FIN,
    S_HALT
  } boot_state_t;

  // exchange the two bytes of a word when requested
  function automatic logic [15:0] swap16(input logic [15:0] w, input logic en);
    return en ? {w[7:0], w[15:8]} : w;
  endfunction

  // 8-bit command placed in the upper byte of the shift word
  function automatic logic [15:0] cmd_word(input logic [7:0] c);
    return {c, 8'h00};
  endfunction

  // read command plus address bits 23:16
  function automatic logic [15:0] read_hi_word(input int unsigned a);
    logic [31:0] v;
    v = a;
    return {CMD_READ, v[23:16]};
  endfunction

  // address bits 15:0
  function automatic logic [15:0] read_lo_word(input int unsigned a);
    logic [31:0] v;
    v = a;
    return v[15:0];
  endfunction

endpackage

// File: rtl/spiboot_shifter.sv
`timescale 1ns/1ps
module spiboot_shifter #(
  parameter int DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        wide,
  input  logic [15:0] tx_word,
  input  logic        miso,
  output logic        sclk,
  output logic        mosi,
  output logic        busy,
  output logic        done,
  output logic [15:0] rx_word
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] tick;
  logic          high_ph;
  logic [4:0]    left;
  logic [15:0]   sreg;
  logic          half_end;

  assign half_end = busy && (tick == CW'(DIV - 1));
  assign sclk     = !(busy && !high_ph);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      tick    <= '0;
      high_ph <= 1'b0;
      left    <= '0;
      sreg    <= '0;
      mosi    <= 1'b0;
      rx_word <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy    <= 1'b1;
        high_ph <= 1'b0;
        tick    <= '0;
        sreg    <= tx_word;
        mosi    <= tx_word[15];
        left    <= wide ? 5'd16 : 5'd8;
      end else if (busy) begin
        tick <= half_end ? '0 : tick + 1'b1;
        if (half_end) begin
          if (!high_ph) begin
            high_ph <= 1'b1;
            rx_word <= {rx_word[14:0], miso};
          end else if (left == 5'd1) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            high_ph <= 1'b0;
            left    <= left - 1'b1;
            sreg    <= {sreg[14:0], 1'b0};
            mosi    <= sreg[14];
          end
        end
      end
    end
  end

  // R1
  mosi_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mosi != $past(mosi)) |-> !sclk);

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/spiboot_store.sv
`timescale 1ns/1ps
module spiboot_store import spiboot_pkg::*; #(
  parameter int          AW         = 20,
  parameter int unsigned START_ADDR = 32'h4000,
  parameter int unsigned END_ADDR   = 32'h10000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          capture,
  input  logic          swap_en,
  input  logic [15:0]   rx_word,
  output logic          last_word,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [15:0]   ram_wdata,
  output logic          crc_clear,
  output logic          crc_valid,
  output logic [15:0]   crc_data
);
  localparam logic [AW-1:0] FIRST = AW'(START_ADDR);
  localparam logic [AW-1:0] FINAL = AW'(END_ADDR - 2);

  logic [AW-1:0] ptr;
  logic [15:0]   word_in;

  assign word_in   = swap16(rx_word, swap_en);
  assign last_word = (ptr == FINAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr       <= FIRST;
      ram_we    <= 1'b0;
      ram_addr  <= '0;
      ram_wdata <= '0;
      crc_clear <= 1'b0;
      crc_valid <= 1'b0;
      crc_data  <= '0;
    end else begin
      ram_we    <= 1'b0;
      crc_valid <= 1'b0;
      crc_clear <= clear;
      if (clear) ptr <= FIRST;
      if (capture) begin
        ram_we    <= 1'b1;
        ram_addr  <= ptr;
        ram_wdata <= word_in;
        crc_valid <= 1'b1;
        crc_data  <= word_in;
        ptr       <= ptr + AW'(2);
      end
    end
  end

  // R5
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ram_addr >= FIRST && ram_addr <= FINAL && !ram_addr[0]));

  // R7
  crc_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crc_valid |-> (ram_we && crc_data == ram_wdata));

endmodule

// File: rtl/spiboot_seq.sv
`timescale 1ns/1ps
module spiboot_seq import spiboot_pkg::*; #(
  parameter int          DIV        = 2,
  parameter int unsigned START_ADDR = 32'h4000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        boot_strap,
  input  logic        swap_strap,
  input  logic        xfer_busy,
  input  logic        xfer_done,
  input  logic        last_word,
  output logic        cs_n,
  output logic        oe,
  output logic        xfer_start,
  output logic        xfer_wide,
  output logic [15:0] xfer_tx,
  output logic        store_clear,
  output logic        store_capture,
  output logic        swap_en,
  output logic        done,
  output logic        skipped
);
  localparam int GAP = 4 * DIV;
  localparam int GW  = $clog2(GAP + 1);

  boot_state_t   state;
  logic [GW-1:0] gap;
  logic          gap_end;

  assign gap_end       = (gap == GW'(GAP - 1));
  assign store_clear   = (state == S_CLR);
  assign store_capture = (state == S_DATA_RUN) && xfer_done;
  assign done          = (state == S_FIN);

  always_comb begin
    xfer_start = 1'b0;
    xfer_wide  = 1'b1;
    xfer_tx    = '0;
    unique case (state)
      S_WAKE_GO: begin
        xfer_start = 1'b1;
        xfer_wide  = 1'b0;
        xfer_tx    = cmd_word(CMD_WAKE);
      end
      S_CMD_GO: begin
        xfer_start = 1'b1;
        xfer_tx    = read_hi_word(START_ADDR);
      end
      S_CMD_RUN: if (xfer_done) begin
        xfer_start = 1'b1;
        xfer_tx    = read_lo_word(START_ADDR);
      end
      S_ADDR_RUN: xfer_start = xfer_done;
      S_DATA_RUN: xfer_start = xfer_done && !last_word;
      S_SLEEP_GO: begin
        xfer_start = 1'b1;
        xfer_wide  = 1'b0;
        xfer_tx    = cmd_word(CMD_SLEEP);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_STRAP;
      cs_n    <= 1'b1;
      oe      <= 1'b0;
      gap     <= '0;
      swap_en <= 1'b0;
      skipped <= 1'b0;
    end else begin
      unique case (state)
        S_STRAP: begin
          swap_en <= swap_strap;
          skipped <= !boot_strap;
          oe      <= boot_strap;
          state   <= boot_strap ? S_CLR : S_FIN;
        end
        S_CLR: begin
          cs_n  <= 1'b0;
          state <= S_WAKE_GO;
        end
        S_WAKE_GO:  state <= S_WAKE_RUN;
        S_WAKE_RUN: if (xfer_done) begin
          cs_n  <= 1'b1;
          gap   <= '0;
          state <= S_GAP1;
        end
        S_GAP1: if (gap_end) begin
          cs_n  <= 1'b0;
          state <= S_CMD_GO;
        end else gap <= gap + 1'b1;
        S_CMD_GO:   state <= S_CMD_RUN;
        S_CMD_RUN:  if (xfer_done) state <= S_ADDR_RUN;
        S_ADDR_RUN: if (xfer_done) state <= S_DATA_RUN;
        S_DATA_RUN: if (xfer_done && last_word) begin
          cs_n  <= 1'b1;
          gap   <= '0;
          state <= S_GAP2;
        end
        S_GAP2: if (gap_end) begin
          cs_n  <= 1'b0;
          state <= S_SLEEP_GO;
        end else gap <= gap + 1'b1;
        S_SLEEP_GO:  state <= S_SLEEP_RUN;
        S_SLEEP_RUN: if (xfer_done) begin
          cs_n  <= 1'b1;
          state <= S_REL;
        end
        S_REL: begin
          oe    <= 1'b0;
          state <= S_FIN;
        end
        S_FIN:   state <= S_HALT;
        default: state <= S_HALT;
      endcase
    end
  end

  // R2
  cs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> $past(xfer_done));

  // R4
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> !xfer_busy);

  // R11
  done_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!oe && cs_n));

  // R10
  skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    skipped |-> (!oe && cs_n));

endmodule

// File: rtl/spiboot_copy.sv
`timescale 1ns/1ps
module spiboot_copy #(
  parameter int          AW         = 20,
  parameter int unsigned START_ADDR = 32'h4000,
  parameter int unsigned END_ADDR   = 32'h10000,
  parameter int          DIV        = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          boot_strap,
  input  logic          swap_strap,
  input  logic          spi_miso,
  output logic          spi_sclk,
  output logic          spi_mosi,
  output logic          spi_cs_n,
  output logic          spi_oe,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [15:0]   ram_wdata,
  output logic          crc_clear,
  output logic          crc_valid,
  output logic [15:0]   crc_data,
  output logic          done,
  output logic          skipped
);
  logic        xfer_start, xfer_wide, xfer_busy, xfer_done;
  logic [15:0] xfer_tx, xfer_rx;
  logic        store_clear, store_capture, swap_en, last_word;

  spiboot_seq #(.DIV(DIV), .START_ADDR(START_ADDR)) u_seq (
    .clk(clk), .rst_n(rst_n), .boot_strap(boot_strap), .swap_strap(swap_strap),
    .xfer_busy(xfer_busy), .xfer_done(xfer_done), .last_word(last_word),
    .cs_n(spi_cs_n), .oe(spi_oe), .xfer_start(xfer_start), .xfer_wide(xfer_wide),
    .xfer_tx(xfer_tx), .store_clear(store_clear), .store_capture(store_capture),
    .swap_en(swap_en), .done(done), .skipped(skipped)
  );

  spiboot_shifter #(.DIV(DIV)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(xfer_start), .wide(xfer_wide),
    .tx_word(xfer_tx), .miso(spi_miso), .sclk(spi_sclk), .mosi(spi_mosi),
    .busy(xfer_busy), .done(xfer_done), .rx_word(xfer_rx)
  );

  spiboot_store #(.AW(AW), .START_ADDR(START_ADDR), .END_ADDR(END_ADDR)) u_store (
    .clk(clk), .rst_n(rst_n), .clear(store_clear), .capture(store_capture),
    .swap_en(swap_en), .rx_word(xfer_rx), .last_word(last_word),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .crc_clear(crc_clear), .crc_valid(crc_valid), .crc_data(crc_data)
  );

  // R5
  last_write_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && ram_addr == AW'(END_ADDR - 2)) |-> spi_cs_n);

endmodule

// File: tb/spiboot_copy_bench.sv
`timescale 1ns/1ps
module spiboot_copy_bench;
  localparam int          AW    = 20;
  localparam int unsigned START = 32'h4000;
  localparam int          NW    = 8;
  localparam int unsigned STOP  = START + 2 * NW;
  localparam int          DIV   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic boot_strap = 1'b1, swap_strap = 1'b0, spi_miso = 1'b0;
  logic spi_sclk, spi_mosi, spi_cs_n, spi_oe, ram_we, crc_clear, crc_valid, done, skipped;
  logic [AW-1:0] ram_addr;
  logic [15:0]   ram_wdata, crc_data;

  always #2 clk = ~clk;

  spiboot_copy #(.AW(AW), .START_ADDR(START), .END_ADDR(STOP), .DIV(DIV)) u_spiboot_copy (
    .clk(clk), .rst_n(rst_n), .boot_strap(boot_strap), .swap_strap(swap_strap),
    .spi_miso(spi_miso), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n),
    .spi_oe(spi_oe), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .crc_clear(crc_clear), .crc_valid(crc_valid), .crc_data(crc_data),
    .done(done), .skipped(skipped)
  );

  int tests = 0, fails = 0, mtests = 0, mfails = 0;
  logic [7:0] salt = 8'h00;
  logic exp_swap = 1'b0;

  function automatic logic [7:0] fbyte(input logic [23:0] a, input logic [7:0] s);
    logic [7:0] t;
    t = (a[7:0] * 8'd29) + (a[15:8] ^ s);
    return t ^ {a[2:0], 5'd0};
  endfunction

  function automatic logic [15:0] exp_word(input int k, input logic [7:0] s, input logic sw);
    logic [23:0] a;
    logic [7:0] hi, lo;
    a  = 24'(START + 2 * k);
    hi = fbyte(a, s);
    lo = fbyte(a + 24'd1, s);
    return sw ? {lo, hi} : {hi, lo};
  endfunction

  // monitor and flash model
  logic prev_sclk, prev_cs, prev_mosi;
  int nframes, bits, gap, wr_cnt, done_cnt, clr_cnt;
  logic [31:0] head;
  logic tail_nz, oe_ever;
  int fr_bits [4];
  logic [31:0] fr_head [4];
  logic fr_tnz [4];

  task automatic mchk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    mtests++;
    if (!ok) begin
      mfails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_sclk = 1'b1; prev_cs = 1'b1; prev_mosi = spi_mosi;
      nframes = 0; bits = 0; gap = 0; wr_cnt = 0; done_cnt = 0; clr_cnt = 0;
      head = '0; tail_nz = 1'b0; oe_ever = 1'b0; spi_miso = 1'b0;
      for (int i = 0; i < 4; i++) begin fr_bits[i] = 0; fr_head[i] = '0; fr_tnz[i] = 1'b0; end
    end else begin
      if (spi_oe) oe_ever = 1'b1;
      if (crc_clear) clr_cnt++;
      // R1 mosi moves only while clock low; idle clock high
      if (!spi_cs_n && spi_mosi != prev_mosi) mchk(!spi_sclk, "R1 mosi edge", 32'(spi_sclk), 0);
      if (spi_oe && spi_cs_n && !spi_sclk) mchk(1'b0, "R1 idle sclk", 0, 1);
      if (prev_cs && !spi_cs_n) begin
        // R9 chip select gap
        if (nframes > 0) mchk(gap >= 4 * DIV, "R9 cs gap", 32'(gap), 32'(4 * DIV));
        bits = 0; head = '0; tail_nz = 1'b0;
      end
      if (!spi_cs_n) begin
        if (!prev_sclk && spi_sclk) begin
          if (bits < 32) head = {head[30:0], spi_mosi};
          else if (spi_mosi) tail_nz = 1'b1;
          bits++;
        end
        if (prev_sclk && !spi_sclk && bits >= 32 && head[31:24] == 8'h03) begin
          logic [7:0] b;
          int idx;
          idx = bits - 32;
          b = fbyte(head[23:0] + 24'(idx / 8), salt);
          spi_miso = b[7 - (idx % 8)];
        end
      end
      if (!prev_cs && spi_cs_n) begin
        if (nframes < 4) begin
          fr_bits[nframes] = bits; fr_head[nframes] = head; fr_tnz[nframes] = tail_nz;
        end
        nframes++;
        gap = 1;
      end else if (spi_cs_n) gap++;
      if (ram_we) begin
        mchk(clr_cnt == 1, "R7 clear before write", 32'(clr_cnt), 1);
        mchk(ram_addr == AW'(START + 2 * wr_cnt), "R5 address", 32'(ram_addr), START + 2 * wr_cnt);
        mchk(ram_wdata == exp_word(wr_cnt, salt, exp_swap), "R5/R6 data", 32'(ram_wdata),
             32'(exp_word(wr_cnt, salt, exp_swap)));
        mchk(crc_valid && crc_data == ram_wdata, "R7 crc feed", 32'(crc_data), 32'(ram_wdata));
        if (wr_cnt == NW - 1) mchk(spi_cs_n, "R5 last store with cs release", 32'(spi_cs_n), 1);
        wr_cnt++;
      end
      if (done) begin
        mchk(!spi_oe, "R11 pins released at done", 32'(spi_oe), 0);
        done_cnt++;
      end
      prev_sclk = spi_sclk; prev_cs = spi_cs_n; prev_mosi = spi_mosi;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic boot_run(input logic boot, input logic swp, input logic flip);
    int waited;
    salt = 8'($urandom);
    boot_strap = boot; swap_strap = swp; exp_swap = swp;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(!spi_oe && spi_cs_n && spi_sclk && !done && !ram_we && !crc_valid && !crc_clear,
        "R12 reset outputs", {spi_oe, spi_cs_n, spi_sclk, done, ram_we, crc_valid, crc_clear},
        {1'b0, 1'b1, 1'b1, 4'b0});
    rst_n = 1'b1;
    waited = 0;
    if (flip) begin
      repeat (200) @(negedge clk);
      swap_strap = ~swp; // R6 late change must be ignored
      waited = 200;
    end
    while (done_cnt == 0 && waited < 6000) begin @(negedge clk); waited++; end
    chk(done_cnt != 0, "WD watchdog", 32'(waited), 6000);
    repeat (30) @(negedge clk);
    chk(done_cnt == 1, "R11 single done pulse", 32'(done_cnt), 1);
    if (boot) begin
      chk(nframes == 3, "R2 frame count", 32'(nframes), 3);
      chk(fr_bits[0] == 8 && fr_head[0][7:0] == 8'hAB, "R2 wake frame",
          {fr_head[0][7:0], 8'(fr_bits[0])}, {8'hAB, 8'd8});
      chk(fr_head[1] == {8'h03, 24'(START)}, "R3 read header", fr_head[1], {8'h03, 24'(START)});
      chk(fr_bits[1] == 32 + 16 * NW && !fr_tnz[1], "R4 stream length and zero fill",
          32'(fr_bits[1]), 32'(32 + 16 * NW));
      chk(fr_bits[2] == 8 && fr_head[2][7:0] == 8'hB9, "R8 power-down frame",
          {fr_head[2][7:0], 8'(fr_bits[2])}, {8'hB9, 8'd8});
      chk(wr_cnt == NW, "R5 word count", 32'(wr_cnt), NW);
      chk(clr_cnt == 1, "R7 crc clear count", 32'(clr_cnt), 1);
      chk(!skipped && !spi_oe, "R11 final pin state", {skipped, spi_oe}, 0);
    end else begin
      chk(nframes == 0 && !oe_ever, "R10 no bus activity", {nframes[15:0], 15'd0, oe_ever}, 0);
      chk(wr_cnt == 0 && clr_cnt == 0, "R10 no writes", 32'(wr_cnt + clr_cnt), 0);
      chk(skipped, "R10 skipped flag", 32'(skipped), 1);
    end
  endtask

  initial begin
    void'($urandom(32'd7411));
    boot_run(1'b1, 1'b0, 1'b0);
    boot_run(1'b1, 1'b1, 1'b0);
    boot_run(1'b0, 1'b0, 1'b0);
    boot_run(1'b1, 1'b1, 1'b1);
    boot_run(1'b1, 1'b0, 1'b1);
    for (int r = 0; r < 4; r++)
      boot_run(($urandom % 4) != 0, 1'($urandom), 1'($urandom));
    $display("[TB] %0d tests run, %0d failed", tests + mtests, fails + mfails);
    $finish;
  end
endmodule